// File: doc/BRIEF.md
# Host Bridge Control Registers and Forwarding Window Decoder

This block is the register side of a processor-to-PCI host bridge. It holds the bridge's own configuration space: a fixed standard header whose words are read-only constants, and three implementation-specific registers placed at or above word index 16 (byte offset 64). These three registers are a 32-bit window mask, a mode word and a 5-bit read hold-off count. Configuration software reaches them through a simple word-indexed access port. A read returns its data one cycle after the request.

The same block decodes the top byte of a processor address against the window mask. It raises `win_hit` when the address falls in a region the bridge should forward. The mask does two jobs. Its high bits enable 256 MB regions across the address space. Its low sixteen bits enable 16 MB regions inside the top 256 MB page. A second output, `ctl_hit`, flags the bridge's own 16 MB control window. The placement of that window, and the reset values of the mask and mode registers, all follow from a 2-bit bridge number strap. Several bridges can therefore share a bus, each owning its own 32 MB slice of the top page.

Top module: `pcib_ctl_regs`

## Requirements
- R1: While reset is held and after it is released, with no write made, the mask reads `3 << (2*bridge_id)`, the mode word reads `(bridge_id << 2) | 3` and the hold-off register reads 8.
- R2: A write to word index 16 (mask) stores all 32 bits, and a later read of that index returns them unchanged.
- R3: A write to word index 20 (hold-off) keeps only bits 4:0, and a read of that index returns zero in bits 31:5.
- R4: A write to word index 18 (mode) stores all 32 bits, and a later read of that index returns them.
- R5: The header words read as follows: index 0 is `{DEVICE_ID, VENDOR_ID}`, index 1 is 0x00000016 (command), index 2 is `0x06000000 | rev_id`, index 3 is 0x00000008 (cache line size). Other indices below 16 read 0. Writes to any index below 16 change nothing.
- R6: Any index at or above 16 other than 16, 18 and 20 reads 0, and a write to it leaves the three registers unchanged.
- R7: For k in 0..14, if mask bit 16+k is set, `win_hit` is 1 for every address whose bits 31:28 equal k.
- R8: For k in 0..15, if mask bit k is set, `win_hit` is 1 for every address whose bits 31:24 equal 0xF0+k. `win_hit` is 0 for any address that no enabled region covers. Mask bit 31 has no effect.
- R9: `win_hit` is combinational from `win_page` and the current mask. A new mask value changes `win_hit` starting in the cycle after the clock edge that accepts the write.
- R10: `ctl_hit` is 1 exactly when the address lies in the 16 MB window starting at `0xF0000000 + (bridge_id << 25)`, that is when `win_page == 0xF0 + 2*bridge_id`.
- R11: A read request accepted at a clock edge puts its data on `cfg_rdata` and raises `cfg_rvalid` for the cycle after that edge. `cfg_rvalid` is low in every cycle not preceded by an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bridge_id | input | 2 | Bridge number strap; must be stable while the block is in use |
| rev_id | input | 8 | Revision number reported in the class word |
| cfg_sel | input | 1 | Access request, accepted at every clock edge where it is high |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_widx | input | 6 | Word index (byte offset divided by 4) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid while cfg_rvalid is high |
| cfg_rvalid | output | 1 | High for one cycle after each accepted read |
| win_page | input | 8 | Processor address bits 31:24 |
| win_hit | output | 1 | Address falls in an enabled forwarding region |
| ctl_hit | output | 1 | Address falls in this bridge's control window |

## Verification
The access port has no back-pressure, so every result has a fixed latency. Read data and `cfg_rvalid` are due in the cycle after the edge that accepts the read. A written value is visible to a read whose request is accepted in any later cycle. The window outputs follow `win_page` with no delay and follow the mask one edge after the write. The bench drives inputs on the falling edge and samples on the next falling edge. For the window outputs it also samples in the same low phase as the write request, to confirm that the old mask still applies there.

// File: rtl/pcib_pkg.sv
`timescale 1ns/1ps
package pcib_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned WIDX_W  = 6;
  localparam int unsigned PAGE_W  = 8;
  localparam int unsigned BRID_W  = 2;

  // header word indices (below the vendor area)
  localparam logic [WIDX_W-1:0] IX_IDENT = 6'd0;
  localparam logic [WIDX_W-1:0] IX_CMD   = 6'd1;
  localparam logic [WIDX_W-1:0] IX_CLASS = 6'd2;
  localparam logic [WIDX_W-1:0] IX_LINE  = 6'd3;

  // first word index of the implementation-specific area (byte 64)
  localparam logic [WIDX_W-1:0] IX_VBASE = 6'd16;

  // implementation-specific registers
  localparam logic [WIDX_W-1:0] IX_WMASK = 6'd16;
  localparam logic [WIDX_W-1:0] IX_MODE  = 6'd18;
  localparam logic [WIDX_W-1:0] IX_HOLD  = 6'd20;

  // window geometry
  localparam int unsigned N_COARSE   = 15;
  localparam int unsigned N_FINE     = 16;
  localparam int unsigned COARSE_LSB = 16;
  localparam logic [3:0]  TOP_NIBBLE = 4'hF;

  typedef struct packed {
    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] mode;
  } vregs_t;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10
  } acc_e;

endpackage

// File: rtl/pcib_hdr_rom.sv
`timescale 1ns/1ps
module pcib_hdr_rom
  import pcib_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1234,
  parameter logic [15:0] DEVICE_ID = 16'h0001,
  parameter logic [15:0] CMD_VAL   = 16'h0016,
  parameter logic [7:0]  LINE_VAL  = 8'd8,
  parameter logic [23:0] CLASS_VAL = 24'h060000
) (
  input  logic [WIDX_W-1:0] widx,
  input  logic [7:0]        rev_id,
  output logic              in_hdr,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [DATA_W-1:0] W_IDENT = {DEVICE_ID, VENDOR_ID};
  localparam logic [DATA_W-1:0] W_CMD   = {16'h0000, CMD_VAL};
  localparam logic [DATA_W-1:0] W_LINE  = {24'h000000, LINE_VAL};

  assign in_hdr = (widx < IX_VBASE);

  always_comb begin
    rdata = '0;
    if (in_hdr) begin
      unique case (widx)
        IX_IDENT: rdata = W_IDENT;
        IX_CMD:   rdata = W_CMD;
        IX_CLASS: rdata = {CLASS_VAL, rev_id};
        IX_LINE:  rdata = W_LINE;
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/pcib_vendor_regs.sv
`timescale 1ns/1ps
module pcib_vendor_regs
  import pcib_pkg::*;
#(
  parameter int unsigned HOLD_W   = 5,
  parameter int unsigned HOLD_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BRID_W-1:0] bridge_id,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  output vregs_t            regs,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned HOLD_PAD = DATA_W - HOLD_W;
  localparam int unsigned SLICE_SH = 2;

  logic [HOLD_W-1:0] hold_q;
  logic [DATA_W-1:0] wmask_rst;
  logic [DATA_W-1:0] mode_rst;

  // reset values follow the bridge number strap
  assign wmask_rst = DATA_W'(3) << (SLICE_SH * bridge_id);
  assign mode_rst  = (DATA_W'(bridge_id) << 2) | DATA_W'(3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs.wmask <= wmask_rst;
      regs.mode  <= mode_rst;
      hold_q     <= HOLD_W'(HOLD_RST);
    end else if (wr_en) begin
      if (widx == IX_WMASK) regs.wmask <= wdata;
      if (widx == IX_MODE)  regs.mode  <= wdata;
      if (widx == IX_HOLD)  hold_q     <= wdata[HOLD_W-1:0];
    end
  end

  always_comb begin
    unique case (widx)
      IX_WMASK: rdata = regs.wmask;
      IX_MODE:  rdata = regs.mode;
      IX_HOLD:  rdata = {{HOLD_PAD{1'b0}}, hold_q};
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/pcib_win_decode.sv
`timescale 1ns/1ps
module pcib_win_decode
  import pcib_pkg::*;
(
  input  logic [PAGE_W-1:0]              page,
  input  logic [COARSE_LSB+N_COARSE-1:0] wmask,
  input  logic [BRID_W-1:0]              bridge_id,
  output logic                           win_hit,
  output logic                           ctl_hit
);

  localparam int unsigned NIB = PAGE_W / 2;

  logic [NIB-1:0]      hi_nib;
  logic [NIB-1:0]      lo_nib;
  logic [N_COARSE-1:0] coarse_hit;
  logic [N_FINE-1:0]   fine_hit;

  assign hi_nib = page[PAGE_W-1:NIB];
  assign lo_nib = page[NIB-1:0];

  for (genvar k = 0; k < N_COARSE; k++) begin : g_coarse
    assign coarse_hit[k] = wmask[COARSE_LSB+k] && (hi_nib == NIB'(k));
  end

  for (genvar k = 0; k < N_FINE; k++) begin : g_fine
    assign fine_hit[k] = wmask[k] && (hi_nib == TOP_NIBBLE) && (lo_nib == NIB'(k));
  end

  assign win_hit = (|coarse_hit) || (|fine_hit);

  // the control window is the first 16 MB of this bridge's 32 MB slice
  assign ctl_hit = (hi_nib == TOP_NIBBLE) && (lo_nib == {1'b0, bridge_id, 1'b0});

endmodule

// File: rtl/pcib_ctl_regs.sv
`timescale 1ns/1ps
module pcib_ctl_regs
  import pcib_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1234,
  parameter logic [15:0] DEVICE_ID = 16'h0001,
  parameter int unsigned HOLD_W    = 5,
  parameter int unsigned HOLD_RST  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bridge_id,
  input  logic [7:0]        rev_id,
  input  logic              cfg_sel,
  input  logic              cfg_we,
  input  logic [5:0]        cfg_widx,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_rvalid,
  input  logic [7:0]        win_page,
  output logic              win_hit,
  output logic              ctl_hit
);

  localparam int unsigned DEC_W = COARSE_LSB + N_COARSE;

  acc_e              acc;
  logic              in_hdr;
  logic [DATA_W-1:0] hdr_rdata;
  logic [DATA_W-1:0] vnd_rdata;
  logic [DATA_W-1:0] mux_rdata;
  vregs_t            regs;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_comb begin
    if (!cfg_sel)    acc = ACC_IDLE;
    else if (cfg_we) acc = ACC_WRITE;
    else             acc = ACC_READ;
  end

  pcib_hdr_rom #(
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID)
  ) u_hdr (
    .widx   (cfg_widx),
    .rev_id (rev_id),
    .in_hdr (in_hdr),
    .rdata  (hdr_rdata)
  );

  pcib_vendor_regs #(
    .HOLD_W   (HOLD_W),
    .HOLD_RST (HOLD_RST)
  ) u_vnd (
    .clk       (clk),
    .rst_n     (rst_n),
    .bridge_id (bridge_id),
    .wr_en     (acc == ACC_WRITE),
    .widx      (cfg_widx),
    .wdata     (cfg_wdata),
    .regs      (regs),
    .rdata     (vnd_rdata)
  );

  assign mask_q    = regs.wmask;
  assign mux_rdata = in_hdr ? hdr_rdata : vnd_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= (acc == ACC_READ);
      if (acc == ACC_READ) rdata_q <= mux_rdata;
    end
  end

  assign cfg_rdata  = rdata_q;
  assign cfg_rvalid = rvalid_q;

  pcib_win_decode u_dec (
    .page      (win_page),
    .wmask     (mask_q[DEC_W-1:0]),
    .bridge_id (bridge_id),
    .win_hit   (win_hit),
    .ctl_hit   (ctl_hit)
  );

  // bit 31 of the mask and the mode word are stored for readback only
  logic unused_ok;
  assign unused_ok = ^{mask_q[DATA_W-1:DEC_W], regs.mode};

endmodule

// File: rtl/pcib_ctl_regs_chk.sv
`timescale 1ns/1ps
module pcib_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bridge_id,
  input logic        cfg_sel,
  input logic        cfg_we,
  input logic [5:0]  cfg_widx,
  input logic [31:0] cfg_rdata,
  input logic        cfg_rvalid,
  input logic [7:0]  win_page,
  input logic        win_hit,
  input logic        ctl_hit,
  input logic [31:0] mask_q
);

  // R11
  rd_resp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel && !cfg_we) |=> cfg_rvalid);

  // R11
  rd_resp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rvalid |-> $past(cfg_sel && !cfg_we));

  // R3
  hold_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rvalid && $past(cfg_widx) == 6'd20) |-> (cfg_rdata[31:5] == 27'd0));

  // R5
  cmd_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rvalid && $past(cfg_widx) == 6'd1) |-> (cfg_rdata == 32'h0000_0016));

  // R7
  coarse_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_page[7:4] != 4'hF && mask_q[{1'b1, win_page[7:4]}]) |-> win_hit);

  // R8
  fine_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_page[7:4] == 4'hF && mask_q[win_page[3:0]]) |-> win_hit);

  // R9
  hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(win_page) && $stable(mask_q)) |-> $stable(win_hit));

  // R10
  ctl_top_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hit |-> (win_page[7:4] == 4'hF && win_page[0] == 1'b0 && win_page[2:1] == bridge_id));

endmodule

bind pcib_ctl_regs pcib_ctl_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bridge_id  (bridge_id),
  .cfg_sel    (cfg_sel),
  .cfg_we     (cfg_we),
  .cfg_widx   (cfg_widx),
  .cfg_rdata  (cfg_rdata),
  .cfg_rvalid (cfg_rvalid),
  .win_page   (win_page),
  .win_hit    (win_hit),
  .ctl_hit    (ctl_hit),
  .mask_q     (mask_q)
);

// File: tb/pcib_ctl_regs_bench.sv
`timescale 1ns/1ps
module pcib_ctl_regs_bench;

  localparam logic [15:0] VID = 16'h1234;
  localparam logic [15:0] DID = 16'h0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bridge_id = 2'd0;
  logic [7:0]  rev_id = 8'h00;
  logic        cfg_sel = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_widx = 6'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic [7:0]  win_page = 8'h00;
  logic        win_hit;
  logic        ctl_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_mask, m_mode, m_hold;

  always #10 clk = ~clk;

  pcib_ctl_regs #(.VENDOR_ID(VID), .DEVICE_ID(DID)) u_pcib_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bridge_id(bridge_id), .rev_id(rev_id),
    .cfg_sel(cfg_sel), .cfg_we(cfg_we), .cfg_widx(cfg_widx), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
    .win_page(win_page), .win_hit(win_hit), .ctl_hit(ctl_hit)
  );

  function automatic logic exp_hit(input logic [31:0] m, input logic [7:0] p);
    logic h = 1'b0;
    for (int k = 0; k < 15; k++) if (m[16+k] && p[7:4] == k[3:0]) h = 1'b1;
    for (int k = 0; k < 16; k++) if (m[k] && p == (8'hF0 + k[7:0])) h = 1'b1;
    return h;
  endfunction

  function automatic logic exp_ctl(input logic [1:0] id, input logic [7:0] p);
    logic [31:0] addr = {p, 24'h0};
    logic [31:0] base = 32'hF000_0000 + ({30'd0, id} << 25);
    return (addr >= base) && (addr < base + 32'h0100_0000);
  endfunction

  function automatic logic [31:0] exp_read(input logic [5:0] ix);
    case (ix)
      6'd0:    return {DID, VID};
      6'd1:    return 32'h16;
      6'd2:    return 32'h0600_0000 | {24'd0, rev_id};
      6'd3:    return 32'h8;
      6'd16:   return m_mask;
      6'd18:   return m_mode;
      6'd20:   return m_hold;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] id);
    @(negedge clk);
    rst_n = 1'b0; bridge_id = id; cfg_sel = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_mask = 32'd3 << (2 * id);
    m_mode = ({30'd0, id} << 2) | 32'd3;
    m_hold = 32'd8;
  endtask

  task automatic cfg_write(input logic [5:0] ix, input logic [31:0] d);
    @(negedge clk);
    cfg_sel = 1'b1; cfg_we = 1'b1; cfg_widx = ix; cfg_wdata = d;
    @(negedge clk);
    cfg_sel = 1'b0; cfg_we = 1'b0;
    if (ix == 6'd16) m_mask = d;
    if (ix == 6'd18) m_mode = d;
    if (ix == 6'd20) m_hold = {27'd0, d[4:0]};
  endtask

  task automatic cfg_read_chk(input string req, input logic [5:0] ix);
    @(negedge clk);
    cfg_sel = 1'b1; cfg_we = 1'b0; cfg_widx = ix;
    @(negedge clk);
    cfg_sel = 1'b0;
    chk({req, " rvalid"}, {31'd0, cfg_rvalid}, 32'd1);
    chk(req, cfg_rdata, exp_read(ix));
  endtask

  task automatic hit_chk(input string req, input logic [7:0] p);
    win_page = p;
    #1;
    chk({req, " win_hit"}, {31'd0, win_hit}, {31'd0, exp_hit(m_mask, p)});
    chk("R10 ctl_hit", {31'd0, ctl_hit}, {31'd0, exp_ctl(bridge_id, p)});
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    // R1 / R10 / R8 for every bridge number
    for (int id = 0; id < 4; id++) begin
      rev_id = 8'(8'h10 + id);
      do_reset(id[1:0]);
      @(negedge clk);
      chk("R11 rvalid idle", {31'd0, cfg_rvalid}, 32'd0);
      cfg_read_chk("R1 mask reset", 6'd16);
      cfg_read_chk("R1 mode reset", 6'd18);
      cfg_read_chk("R1 hold reset", 6'd20);
      hit_chk("R8 own slice lo", 8'hF0 + 8'(2 * id));
      hit_chk("R8 own slice hi", 8'hF1 + 8'(2 * id));
      hit_chk("R8 other slice", 8'hF0 + 8'((2 * id + 2) % 16));
    end
    // R5 header and write immunity
    rev_id = 8'hA5;
    for (int ix = 0; ix < 16; ix++) cfg_read_chk("R5 header", ix[5:0]);
    cfg_write(6'd1, 32'hFFFF_FFFF);
    cfg_write(6'd3, 32'h0000_00FF);
    cfg_write(6'd0, 32'h0);
    cfg_read_chk("R5 cmd after write", 6'd1);
    cfg_read_chk("R5 line after write", 6'd3);
    cfg_read_chk("R5 ident after write", 6'd0);
    // R6 unimplemented vendor offsets
    cfg_write(6'd17, 32'hDEAD_BEEF);
    cfg_write(6'd63, 32'hFFFF_FFFF);
    cfg_read_chk("R6 unimpl read", 6'd17);
    cfg_read_chk("R6 unimpl read", 6'd63);
    cfg_read_chk("R6 mask kept", 6'd16);
    cfg_read_chk("R6 mode kept", 6'd18);
    cfg_read_chk("R6 hold kept", 6'd20);
    // R3 hold truncation, R4 mode, R2 mask
    cfg_write(6'd20, 32'hFFFF_FFFF);
    cfg_read_chk("R3 hold trunc", 6'd20);
    cfg_write(6'd18, 32'h8765_4321);
    cfg_read_chk("R4 mode", 6'd18);
    cfg_write(6'd16, 32'hFFFF_FFFF);
    cfg_read_chk("R2 mask all", 6'd16);
    hit_chk("R8 bit31 no effect", 8'hF7);
    // R9 directed: new mask applies only after the accepting edge
    cfg_write(6'd16, 32'h0);
    win_page = 8'h30;
    @(negedge clk);
    cfg_sel = 1'b1; cfg_we = 1'b1; cfg_widx = 6'd16; cfg_wdata = 32'h0008_0000;
    #1;
    chk("R9 old mask same cycle", {31'd0, win_hit}, 32'd0);
    @(negedge clk);
    cfg_sel = 1'b0; cfg_we = 1'b0; m_mask = 32'h0008_0000;
    chk("R9 R7 new mask next cycle", {31'd0, win_hit}, 32'd1);
    hit_chk("R7 coarse miss", 8'h40);
    // random mix
    for (int it = 0; it < 300; it++) begin
      int unsigned r = $urandom % 4;
      if (r == 0) begin
        logic [31:0] m = $urandom;
        if ($urandom % 2) m = m & 32'h0000_FFFF;
        cfg_write(6'd16, m);
      end else if (r == 1) begin
        cfg_write(6'($urandom % 64), $urandom);
      end else if (r == 2) begin
        cfg_read_chk("R2 R6 random read", 6'($urandom % 64));
      end
      for (int j = 0; j < 3; j++) begin
        logic [7:0] p = 8'($urandom);
        if (j == 0) p[7:4] = 4'hF;
        hit_chk("R7 R8 random", p);
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule